// File: doc/BRIEF.md
# Doorbell Interrupt Register Block

This block is a small slave on a 32-bit memory-mapped bus. It holds five 32-bit words: two outbound descriptor words, a control word, an interrupt status word and a software-interrupt word. It also drives one level-sensitive interrupt line toward the chip's interrupt controller. Software reaches the words through a 4 KiB window. Every access is a full 32-bit little-endian word, and offsets that are not word-aligned count as unmapped.

The interrupt line is a sticky flag. It is not computed from the stored words. Particular writes raise it and other writes lower it, and every other access leaves it where it was. The line changes on the clock edge that accepts the write. A read of the control word always shows one status bit as set. The bus is a single-cycle handshake made of valid, write, address and data. Read data is registered and appears on the cycle after the request. It then holds until the next read.

Top module: `doorbell_regs`

## Requirements
- R1: A synchronous reset clears all five words, drives the interrupt output low and drives the read data to zero.
- R2: A write to descriptor A (offset 0x28), descriptor B (0x2C) or status (0x50) stores the full data word. A later read of the same offset returns that word.
- R3: A write to descriptor B with data bit 29 set drives the interrupt high. With bit 29 clear, the interrupt level is left unchanged.
- R4: A write to control (0x4C) stores the data, and data bit 16 set drives the interrupt low. A read of control returns the stored word with bit 17 forced to 1.
- R5: A write to status with data bit 16 or bit 29 set drives the interrupt low. With both bits clear, the interrupt level is left unchanged.
- R6: A write to the software-set offset (0x1F0) ORs the data into the software-interrupt word and always drives the interrupt high.
- R7: A write to the software-clear offset (0x1F4) clears each software-interrupt bit that is 1 in the data. It always drives the interrupt low, even if some bits stay set.
- R8: A read of either 0x1F0 or 0x1F4 returns the current software-interrupt word.
- R9: A read of an unmapped or misaligned offset returns zero. A write to one changes no word and leaves the interrupt level unchanged.
- R10: The interrupt output changes on the first clock edge after the accepted write. Read data is valid one cycle after the read request and holds while no read is made.
- R11: A write to descriptor A never changes the interrupt level, whatever its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busValid | input | 1 | Access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte offset inside the 4 KiB window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| irqOut | output | 1 | Level-sensitive interrupt |

## Verification
The interrupt rules are driven with matched pairs of writes. Each pair sends the same offset once with the trigger bit set and once with it clear, so a decoder that ignores the data bit, or that uses the wrong bit, shows a wrong level. The software-set and software-clear writes are mixed so that bits remain set after a clear. This separates a sticky flag from a line derived from the register contents. Unmapped and misaligned writes go in while the line is both high and low, and each is followed by reads. These reads show whether an alias reached a stored word. Back-to-back reads and idle gaps confirm the one-cycle read latency and that the read data holds between reads.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;

  // Word offsets inside the window
  localparam int unsigned OFF_DESC_A = 'h028;
  localparam int unsigned OFF_DESC_B = 'h02C;
  localparam int unsigned OFF_CTRL   = 'h04C;
  localparam int unsigned OFF_STAT   = 'h050;
  localparam int unsigned OFF_SW_SET = 'h1F0;
  localparam int unsigned OFF_SW_CLR = 'h1F4;

  // Data bits that steer the interrupt flag
  localparam int unsigned BIT_DESC_RAISE = 29;
  localparam int unsigned BIT_CTRL_LOWER = 16;
  localparam int unsigned BIT_STAT_LOW_A = 16;
  localparam int unsigned BIT_STAT_LOW_B = 29;
  localparam int unsigned BIT_CTRL_FORCE = 17;

  // Indices of the plain store-and-read words
  localparam int unsigned NUM_PLAIN = 4;
  localparam int unsigned IDX_DESC_A = 0;
  localparam int unsigned IDX_DESC_B = 1;
  localparam int unsigned IDX_CTRL   = 2;
  localparam int unsigned IDX_STAT   = 3;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_DESC_A,
    RD_DESC_B,
    RD_CTRL,
    RD_STAT,
    RD_SWI
  } rdSel_e;

  typedef struct packed {
    logic [NUM_PLAIN-1:0] plainWr;
    logic                 swSet;
    logic                 swClr;
    logic                 irqRaise;
    logic                 irqLower;
    logic                 rdEn;
    rdSel_e               rdSel;
  } regStrobe_t;

endpackage

// File: rtl/doorbell_ctrl.sv
module doorbell_ctrl
  import doorbell_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output regStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] A_DESC_A = ADDR_W'(OFF_DESC_A);
  localparam logic [ADDR_W-1:0] A_DESC_B = ADDR_W'(OFF_DESC_B);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_SW_SET = ADDR_W'(OFF_SW_SET);
  localparam logic [ADDR_W-1:0] A_SW_CLR = ADDR_W'(OFF_SW_CLR);

  logic wrReq;
  logic rdReq;

  assign wrReq = busValid && busWrite;
  assign rdReq = busValid && !busWrite;

  // Write decode: which word to load and which way the flag moves
  always_comb begin
    strobe.plainWr  = '0;
    strobe.swSet    = 1'b0;
    strobe.swClr    = 1'b0;
    strobe.irqRaise = 1'b0;
    strobe.irqLower = 1'b0;
    if (wrReq) begin
      unique case (busAddr)
        A_DESC_A: strobe.plainWr[IDX_DESC_A] = 1'b1;
        A_DESC_B: begin
          strobe.plainWr[IDX_DESC_B] = 1'b1;
          strobe.irqRaise = busWdata[BIT_DESC_RAISE];
        end
        A_CTRL: begin
          strobe.plainWr[IDX_CTRL] = 1'b1;
          strobe.irqLower = busWdata[BIT_CTRL_LOWER];
        end
        A_STAT: begin
          strobe.plainWr[IDX_STAT] = 1'b1;
          strobe.irqLower = busWdata[BIT_STAT_LOW_A] | busWdata[BIT_STAT_LOW_B];
        end
        A_SW_SET: begin
          strobe.swSet    = 1'b1;
          strobe.irqRaise = 1'b1;
        end
        A_SW_CLR: begin
          strobe.swClr    = 1'b1;
          strobe.irqLower = 1'b1;
        end
        default: ;
      endcase
    end
  end

  // Read decode: select source, unmapped selects zero
  always_comb begin
    strobe.rdEn  = rdReq;
    strobe.rdSel = RD_NONE;
    if (rdReq) begin
      unique case (busAddr)
        A_DESC_A: strobe.rdSel = RD_DESC_A;
        A_DESC_B: strobe.rdSel = RD_DESC_B;
        A_CTRL:   strobe.rdSel = RD_CTRL;
        A_STAT:   strobe.rdSel = RD_STAT;
        A_SW_SET,
        A_SW_CLR: strobe.rdSel = RD_SWI;
        default:  strobe.rdSel = RD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/doorbell_dp.sv
module doorbell_dp
  import doorbell_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);

  localparam logic [DATA_W-1:0] CTRL_FORCE_MASK = DATA_W'(1) << BIT_CTRL_FORCE;

  logic [DATA_W-1:0] plainWord [NUM_PLAIN];
  logic [DATA_W-1:0] swWord;
  logic [DATA_W-1:0] rdMux;
  logic              irqFlag;

  // Plain words: load on their strobe, clear on reset
  for (genvar gi = 0; gi < NUM_PLAIN; gi++) begin : g_plain
    always_ff @(posedge clk) begin
      if (rst) begin
        plainWord[gi] <= '0;
      end else if (strobe.plainWr[gi]) begin
        plainWord[gi] <= busWdata;
      end
    end
  end

  // Software-interrupt word: bitwise set and clear
  always_ff @(posedge clk) begin
    if (rst) begin
      swWord <= '0;
    end else if (strobe.swSet) begin
      swWord <= swWord | busWdata;
    end else if (strobe.swClr) begin
      swWord <= swWord & ~busWdata;
    end
  end

  // Sticky interrupt flag, moved only by strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      irqFlag <= 1'b0;
    end else if (strobe.irqRaise) begin
      irqFlag <= 1'b1;
    end else if (strobe.irqLower) begin
      irqFlag <= 1'b0;
    end
  end

  always_comb begin
    unique case (strobe.rdSel)
      RD_DESC_A: rdMux = plainWord[IDX_DESC_A];
      RD_DESC_B: rdMux = plainWord[IDX_DESC_B];
      RD_CTRL:   rdMux = plainWord[IDX_CTRL] | CTRL_FORCE_MASK;
      RD_STAT:   rdMux = plainWord[IDX_STAT];
      RD_SWI:    rdMux = swWord;
      default:   rdMux = '0;
    endcase
  end

  // Registered read data, held between reads
  always_ff @(posedge clk) begin
    if (rst) begin
      busRdata <= '0;
    end else if (strobe.rdEn) begin
      busRdata <= rdMux;
    end
  end

  assign irqOut = irqFlag;

endmodule

// File: rtl/doorbell_regs.sv
module doorbell_regs
  import doorbell_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);

  regStrobe_t strobe;

  doorbell_ctrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_ctrl (
    .busValid(busValid),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .strobe  (strobe)
  );

  doorbell_dp #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .irqOut  (irqOut)
  );

endmodule

// File: rtl/doorbell_chk.sv
module doorbell_chk
  import doorbell_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              irqOut
);

  logic wr;
  logic rd;
  logic mapped;

  assign wr = busValid && busWrite;
  assign rd = busValid && !busWrite;
  assign mapped = (busAddr == ADDR_W'(OFF_DESC_A)) || (busAddr == ADDR_W'(OFF_DESC_B)) ||
                  (busAddr == ADDR_W'(OFF_CTRL))   || (busAddr == ADDR_W'(OFF_STAT))   ||
                  (busAddr == ADDR_W'(OFF_SW_SET)) || (busAddr == ADDR_W'(OFF_SW_CLR));

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!irqOut && busRdata == '0));

  // R3
  desc_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && busAddr == ADDR_W'(OFF_DESC_B) && busWdata[BIT_DESC_RAISE]) |=> irqOut);

  // R4
  ctrl_lower_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && busAddr == ADDR_W'(OFF_CTRL) && busWdata[BIT_CTRL_LOWER]) |=> !irqOut);

  // R4
  ctrl_force_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && busAddr == ADDR_W'(OFF_CTRL)) |=> busRdata[BIT_CTRL_FORCE]);

  // R5
  stat_lower_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && busAddr == ADDR_W'(OFF_STAT) &&
     (busWdata[BIT_STAT_LOW_A] || busWdata[BIT_STAT_LOW_B])) |=> !irqOut);

  // R6
  sw_set_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && busAddr == ADDR_W'(OFF_SW_SET)) |=> irqOut);

  // R7
  sw_clr_lower_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && busAddr == ADDR_W'(OFF_SW_CLR)) |=> !irqOut);

  // R9
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && !mapped) |=> (busRdata == '0));

  // R9
  unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && !mapped) |=> $stable(irqOut));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(busRdata));

  // R11
  desc_a_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && busAddr == ADDR_W'(OFF_DESC_A)) |=> $stable(irqOut));

endmodule

bind doorbell_regs doorbell_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/doorbell_regs_test.sv
`timescale 1ns/100ps
module doorbell_regs_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        busValid;
  logic        busWrite;
  logic [11:0] busAddr;
  logic [31:0] busWdata;
  logic [31:0] busRdata;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Behavioural reference state
  logic [31:0] mDescA, mDescB, mCtrl, mStat, mSw, mRd;
  logic        mIrq;

  always #2.5 clk = ~clk;

  doorbell_regs uut (
    .clk(clk), .rst(rst), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  task automatic compare(input string tag);
    checks++;
    if (irqOut !== mIrq) begin
      errors++;
      $display("FAIL %s irqOut actual=%0b expected=%0b", tag, irqOut, mIrq);
    end
    checks++;
    if (busRdata !== mRd) begin
      errors++;
      $display("FAIL %s busRdata actual=%h expected=%h", tag, busRdata, mRd);
    end
  endtask

  // One bus cycle driven at a falling edge, checked at the next one
  task automatic busOp(input bit isWr, input logic [11:0] a, input logic [31:0] d,
                       input string tag);
    busValid = 1'b1; busWrite = isWr; busAddr = a; busWdata = d;
    if (isWr) begin
      case (a)
        12'h028: mDescA = d;
        12'h02C: begin mDescB = d; if (d[29]) mIrq = 1'b1; end
        12'h04C: begin mCtrl = d; if (d[16]) mIrq = 1'b0; end
        12'h050: begin mStat = d; if (d[16] || d[29]) mIrq = 1'b0; end
        12'h1F0: begin mSw = mSw | d; mIrq = 1'b1; end
        12'h1F4: begin mSw = mSw & ~d; mIrq = 1'b0; end
        default: ;
      endcase
    end else begin
      case (a)
        12'h028: mRd = mDescA;
        12'h02C: mRd = mDescB;
        12'h04C: mRd = mCtrl | 32'h0002_0000;
        12'h050: mRd = mStat;
        12'h1F0, 12'h1F4: mRd = mSw;
        default: mRd = 32'h0;
      endcase
    end
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
    compare(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare(tag);
    end
  endtask

  initial begin
    rst = 1'b1; busValid = 1'b0; busWrite = 1'b0; busAddr = '0; busWdata = '0;
    mDescA = '0; mDescB = '0; mCtrl = '0; mStat = '0; mSw = '0; mRd = '0; mIrq = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    compare("R1");
    busOp(0, 12'h028, 0, "R1");
    busOp(0, 12'h1F0, 0, "R1");

    // R2 store and read back
    busOp(1, 12'h028, 32'hDEAD_BEEF, "R2");
    busOp(1, 12'h02C, 32'h1234_5678, "R2");
    busOp(1, 12'h050, 32'h0000_00A5, "R2");
    busOp(0, 12'h028, 0, "R2");
    busOp(0, 12'h02C, 0, "R2");
    busOp(0, 12'h050, 0, "R2");

    // R3 raise via descriptor B bit 29, and no change without it
    busOp(1, 12'h02C, 32'h2000_0000, "R3");
    busOp(1, 12'h02C, 32'hDFFF_FFFF, "R3");
    // R11 descriptor A never moves the flag
    busOp(1, 12'h028, 32'hFFFF_FFFF, "R11");
    // R5 status write without the lowering bits leaves flag high
    busOp(1, 12'h050, 32'hDFFE_FFFF, "R5");
    busOp(1, 12'h050, 32'h0001_0000, "R5");
    busOp(1, 12'h028, 32'h2000_0000, "R11");
    busOp(1, 12'h02C, 32'h2000_0000, "R3");
    busOp(1, 12'h050, 32'h2000_0000, "R5");

    // R4 control store, lower, forced bit on read
    busOp(1, 12'h02C, 32'h2000_0000, "R3");
    busOp(1, 12'h04C, 32'hFFFE_FFFF, "R4");
    busOp(0, 12'h04C, 0, "R4");
    busOp(1, 12'h04C, 32'h0001_0000, "R4");
    busOp(0, 12'h04C, 0, "R4");
    busOp(1, 12'h04C, 32'h0000_0000, "R4");
    busOp(0, 12'h04C, 0, "R4");

    // R6 software set ORs and raises
    busOp(1, 12'h1F0, 32'h0000_0005, "R6");
    busOp(1, 12'h1F0, 32'h0000_0030, "R6");
    busOp(1, 12'h1F0, 32'h0, "R6");
    busOp(0, 12'h1F0, 0, "R8");
    busOp(0, 12'h1F4, 0, "R8");

    // R7 software clear lowers even with bits left
    busOp(1, 12'h1F4, 32'h0000_0004, "R7");
    busOp(0, 12'h1F4, 0, "R8");
    busOp(1, 12'h1F0, 32'h0, "R6");
    busOp(1, 12'h1F4, 32'h0, "R7");
    busOp(0, 12'h1F0, 0, "R8");

    // R9 unmapped and misaligned accesses, flag high then low
    busOp(1, 12'h1F0, 32'h8000_0000, "R6");
    busOp(1, 12'h02E, 32'hFFFF_FFFF, "R9");
    busOp(1, 12'h054, 32'hFFFF_FFFF, "R9");
    busOp(1, 12'h1F8, 32'hFFFF_FFFF, "R9");
    busOp(1, 12'h1F4, 32'h0, "R7");
    busOp(1, 12'hFFC, 32'h2001_0000, "R9");
    busOp(1, 12'h029, 32'h2000_0000, "R9");
    busOp(0, 12'h000, 0, "R9");
    busOp(0, 12'h02D, 0, "R9");
    busOp(0, 12'h028, 0, "R9");
    busOp(0, 12'h02C, 0, "R9");
    busOp(0, 12'h050, 0, "R9");
    busOp(0, 12'h1F0, 0, "R9");

    // R10 latency: back-to-back reads and holding through idle cycles
    busOp(0, 12'h04C, 0, "R10");
    busOp(0, 12'h028, 0, "R10");
    idle(4, "R10");
    busOp(1, 12'h02C, 32'h2000_0000, "R10");
    idle(3, "R10");

    // R1 reset mid-run
    rst = 1'b1;
    mDescA = '0; mDescB = '0; mCtrl = '0; mStat = '0; mSw = '0; mRd = '0; mIrq = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    compare("R1");
    busOp(0, 12'h02C, 0, "R1");
    busOp(0, 12'h04C, 0, "R1");
    busOp(0, 12'h1F4, 0, "R1");

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule